// File: doc/BRIEF.md
# Dual-Line Multichannel ADC Readout Controller

This block sits on the host side of a serial link to an eight-channel simultaneous-sampling converter. The converter returns each channel as a 14-bit word. On a start pulse the block drops chip select, produces a serial clock by dividing the system clock, and shifts in the words on one or two serial data lines. It can read with both lines at once, so that each line carries four channels. It can also read with a single line, either line A or line B, which carries all eight channels.

The order of the words depends on the line. The block places every word into the register for its own channel, whatever the order it arrived in. When the last word is stored, the block pulses a done strobe. Chip select can stay low for the whole transfer, or it can be raised between words. The block watches the converter's BUSY signal and never samples in the cycle where BUSY falls, because the converter's output registers change at that moment.

Top module: `adcr_readout`

## Requirements
- R1: While reset is active and after it is released, `cs_n_o` and `sclk_o` are high, `done_o` is low and every channel register is zero.
- R2: Each word is 14 bits, arrives MSB first and is sampled on a falling edge of `sclk_o`. Channel k (k = 1..8) sits at `ch_data_o[(k-1)*14 +: 14]`. `mode_i` encodes 00 as dual line, 01 as single line A, 10 as single line B and 11 as dual line.
- R3: In dual-line mode a transfer has exactly 56 serial clock falls. Line A fills channels 1 to 4 in ascending order, and line B fills channels 5 to 8 in ascending order.
- R4: In single-line-A mode a transfer has exactly 112 falls and fills channels 1 to 8 in ascending order. Line B has no effect on the result.
- R5: In single-line-B mode a transfer has 112 falls, and the words arrive for channels 5, 6, 7, 8, 1, 2, 3, 4. Line A has no effect on the result.
- R6: With `word_frame_i` low, chip select stays low for one frame covering the whole transfer. With it high, each word gets its own chip-select frame of exactly 14 falls. Chip select rises only at a word boundary, and `sclk_o` is high whenever chip select is high.
- R7: No falling edge of `sclk_o` is issued in the cycle that follows a high-to-low change of `busy_i`. The sample waits instead.
- R8: Every low phase of `sclk_o` lasts exactly `HALF_DIV` system clocks. A high phase lasts at least `HALF_DIV` clocks.
- R9: A start pulse that arrives while a transfer is running is ignored. It does not start another transfer and does not cause an extra done pulse.
- R10: `done_o` is high for exactly one clock per transfer, after the last word has been stored. The channel registers change only when a word completes.
- R11: The block latches `mode_i` and `word_frame_i` when a transfer starts. Changing them during the transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a read |
| mode_i | input | 2 | Line mode: 00 dual, 01 single A, 10 single B, 11 dual |
| word_frame_i | input | 1 | 1 = a separate chip-select frame for each word |
| busy_i | input | 1 | Converter busy flag |
| sdo_a_i | input | 1 | Serial data line A |
| sdo_b_i | input | 1 | Serial data line B |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, high when idle |
| done_o | output | 1 | One-cycle strobe when all eight results are stored |
| ch_data_o | output | 112 | Eight 14-bit channel results, channel 1 in the low bits |

## Verification
The hardest case to reach is a BUSY falling edge that lands exactly on the cycle where a sampling edge is due. Only then does the lockout hold a serial clock high phase beyond its nominal length. To reach it, the stimulus toggles BUSY at random on every cycle during many transfers. A converter model in the bench serves the words only on the serial clock edges it actually sees, so a stalled or an extra edge corrupts the returned data.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_GAP   = 3'd4
  } rd_state_t;

  typedef enum logic [1:0] {
    RD_DUAL  = 2'd0,
    RD_SNG_A = 2'd1,
    RD_SNG_B = 2'd2,
    RD_RSVD  = 2'd3
  } rd_mode_t;

endpackage

// File: rtl/adcr_clkdiv.sv
module adcr_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (!run_i || restart_i) begin
      cnt_n = '0;
    end else if (cnt_q != LAST) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);

  // R8: a freshly started phase never ends on the next clock when the divider exceeds one
  assert_phase_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (HALF_DIV > 1 && restart_i && run_i) |=> !tick_o);

endmodule

// File: rtl/adcr_capture.sv
module adcr_capture #(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              sdo_a_i,
  input  logic              sdo_b_i,
  output logic [WORD_W-1:0] word_a_o,
  output logic [WORD_W-1:0] word_b_o
);
  localparam int SH_W = WORD_W - 1;

  logic [SH_W-1:0] sh_a_q, sh_a_n;
  logic [SH_W-1:0] sh_b_q, sh_b_n;

  always_comb begin
    sh_a_n = sh_a_q;
    sh_b_n = sh_b_q;
    if (sample_i) begin
      sh_a_n = {sh_a_q[SH_W-2:0], sdo_a_i};
      sh_b_n = {sh_b_q[SH_W-2:0], sdo_b_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_a_q <= '0;
      sh_b_q <= '0;
    end else begin
      sh_a_q <= sh_a_n;
      sh_b_q <= sh_b_n;
    end
  end

  // the word is complete in the cycle its last bit is sampled
  assign word_a_o = {sh_a_q, sdo_a_i};
  assign word_b_o = {sh_b_q, sdo_b_i};

endmodule

// File: rtl/adcr_seq.sv
module adcr_seq
  import adcr_pkg::*;
#(
  parameter int WORD_W = 14,
  parameter int NUM_CH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             frame_i,
  input  logic             busy_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             restart_o,
  output logic             sample_o,
  output logic             word_done_o,
  output logic [$clog2(NUM_CH+1)-1:0] word_idx_o,
  output rd_mode_t         mode_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             done_o
);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int IDX_W  = $clog2(NUM_CH + 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] N_DUAL   = IDX_W'(NUM_CH / 2);
  localparam logic [IDX_W-1:0] N_SINGLE = IDX_W'(NUM_CH);

  rd_state_t        state_q, state_n;
  rd_mode_t         mode_q, mode_n;
  logic             frame_q, frame_n;
  logic             busy_q;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic [IDX_W-1:0] wrd_q, wrd_n;
  logic             cs_q, cs_n;
  logic             sclk_q, sclk_n;
  logic             done_q, done_n;
  logic             busy_fall;
  logic [IDX_W-1:0] n_words;
  logic             go, smp;

  assign busy_fall = busy_q && !busy_i;
  assign n_words   = (mode_q == RD_SNG_A || mode_q == RD_SNG_B) ? N_SINGLE : N_DUAL;

  always_comb begin
    state_n = state_q;
    mode_n  = mode_q;
    frame_n = frame_q;
    bit_n   = bit_q;
    wrd_n   = wrd_q;
    cs_n    = cs_q;
    sclk_n  = sclk_q;
    done_n  = 1'b0;
    go      = 1'b0;
    smp     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_n = ST_SETUP;
          mode_n  = rd_mode_t'(mode_i);
          frame_n = frame_i;
          bit_n   = '0;
          wrd_n   = '0;
          cs_n    = 1'b0;
        end
      end
      ST_SETUP, ST_HIGH: begin
        if (tick_i && !busy_fall) begin
          go      = 1'b1;
          smp     = 1'b1;
          sclk_n  = 1'b0;
          state_n = ST_LOW;
          if (bit_q == BIT_LAST) begin
            bit_n = '0;
            wrd_n = wrd_q + 1'b1;
          end else begin
            bit_n = bit_q + 1'b1;
          end
        end
      end
      ST_LOW: begin
        if (tick_i) begin
          go     = 1'b1;
          sclk_n = 1'b1;
          if (bit_q == '0 && wrd_q == n_words) begin
            state_n = ST_IDLE;
            cs_n    = 1'b1;
            done_n  = 1'b1;
          end else if (bit_q == '0 && frame_q) begin
            state_n = ST_GAP;
            cs_n    = 1'b1;
          end else begin
            state_n = ST_HIGH;
          end
        end
      end
      ST_GAP: begin
        if (tick_i) begin
          go      = 1'b1;
          cs_n    = 1'b0;
          state_n = ST_SETUP;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= RD_DUAL;
      frame_q <= 1'b0;
      busy_q  <= 1'b0;
      bit_q   <= '0;
      wrd_q   <= '0;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      mode_q  <= mode_n;
      frame_q <= frame_n;
      busy_q  <= busy_i;
      bit_q   <= bit_n;
      wrd_q   <= wrd_n;
      cs_q    <= cs_n;
      sclk_q  <= sclk_n;
      done_q  <= done_n;
    end
  end

  assign run_o       = (state_q != ST_IDLE);
  assign restart_o   = go;
  assign sample_o    = smp;
  assign word_done_o = smp && (bit_q == BIT_LAST);
  assign word_idx_o  = wrd_q;
  assign mode_o      = mode_q;
  assign cs_n_o      = cs_q;
  assign sclk_o      = sclk_q;
  assign done_o      = done_q;

  // R9: a start pulse during a transfer leaves the latched mode untouched
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> $stable(mode_q));

  // R10: the done strobe lasts a single clock
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: chip select is raised only on a word boundary
  assert_cs_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> (bit_q == '0));

endmodule

// File: rtl/adcr_readout.sv
module adcr_readout
  import adcr_pkg::*;
#(
  parameter int WORD_W   = 14,
  parameter int NUM_CH   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [1:0]               mode_i,
  input  logic                     word_frame_i,
  input  logic                     busy_i,
  input  logic                     sdo_a_i,
  input  logic                     sdo_b_i,
  output logic                     cs_n_o,
  output logic                     sclk_o,
  output logic                     done_o,
  output logic [NUM_CH*WORD_W-1:0] ch_data_o
);
  localparam int HALF_CH = NUM_CH / 2;
  localparam int IDX_W   = $clog2(NUM_CH + 1);

  logic             rst_meta_q, rst_core_q;
  logic             run, restart, tick, sample, word_done;
  logic [IDX_W-1:0] word_idx;
  rd_mode_t         mode_q;
  logic [WORD_W-1:0] word_a, word_b, prim_word;
  int               prim_slot, sec_slot;
  logic             dual, sng_b;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_q <= rst_meta_q;
    end
  end

  adcr_seq #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_q),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .frame_i    (word_frame_i),
    .busy_i     (busy_i),
    .tick_i     (tick),
    .run_o      (run),
    .restart_o  (restart),
    .sample_o   (sample),
    .word_done_o(word_done),
    .word_idx_o (word_idx),
    .mode_o     (mode_q),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .done_o     (done_o)
  );

  adcr_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_core_q),
    .run_i    (run),
    .restart_i(restart),
    .tick_o   (tick)
  );

  adcr_capture #(.WORD_W(WORD_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_core_q),
    .sample_i(sample),
    .sdo_a_i (sdo_a_i),
    .sdo_b_i (sdo_b_i),
    .word_a_o(word_a),
    .word_b_o(word_b)
  );

  // channel placement: line B in single mode starts at the upper half
  always_comb begin
    dual      = (mode_q == RD_DUAL) || (mode_q == RD_RSVD);
    sng_b     = (mode_q == RD_SNG_B);
    prim_word = sng_b ? word_b : word_a;
    prim_slot = int'(word_idx) + (sng_b ? HALF_CH : 0);
    if (prim_slot >= NUM_CH) begin
      prim_slot = prim_slot - NUM_CH;
    end
    sec_slot  = int'(word_idx) + HALF_CH;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [WORD_W-1:0] ch_q, ch_n;

    always_comb begin
      ch_n = ch_q;
      if (word_done && prim_slot == g) begin
        ch_n = prim_word;
      end else if (word_done && dual && sec_slot == g) begin
        ch_n = word_b;
      end
    end

    always_ff @(posedge clk or negedge rst_core_q) begin
      if (!rst_core_q) begin
        ch_q <= '0;
      end else begin
        ch_q <= ch_n;
      end
    end

    assign ch_data_o[g*WORD_W +: WORD_W] = ch_q;
  end

  // R7: no serial clock fall right after BUSY dropped
  assert_busy_lockout_R7: assert property (@(posedge clk) disable iff (!rst_core_q)
    ($past(sclk_o) && !sclk_o) |-> !($past(busy_i, 2) && !$past(busy_i)));

  // R6: serial clock idles high outside chip-select frames
  assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_core_q)
    cs_n_o |-> sclk_o);

  // R10: channel registers only move when a word completes
  assert_ch_hold_R10: assert property (@(posedge clk) disable iff (!rst_core_q)
    !word_done |=> $stable(ch_data_o));

endmodule

// File: tb/adcr_readout_test.sv
module adcr_readout_test;
  localparam int WORD_W = 14;
  localparam int NUM_CH = 8;
  localparam int HALF_DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic word_frame_i = 1'b0;
  logic busy_i = 1'b0;
  logic sdo_a_i = 1'b0;
  logic sdo_b_i = 1'b0;
  logic cs_n_o, sclk_o, done_o;
  logic [NUM_CH*WORD_W-1:0] ch_data_o;

  adcr_readout #(.WORD_W(WORD_W), .NUM_CH(NUM_CH), .HALF_DIV(HALF_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .word_frame_i(word_frame_i), .busy_i(busy_i), .sdo_a_i(sdo_a_i),
    .sdo_b_i(sdo_b_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .done_o(done_o),
    .ch_data_o(ch_data_o));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [WORD_W-1:0] exp_ch [NUM_CH];
  logic [WORD_W-1:0] junk [NUM_CH];
  logic [1:0] x_mode = 2'd0;
  bit busy_rand = 1'b0;

  // monitor / converter model state
  logic sclk_p = 1'b1, cs_p = 1'b1, busy_p = 1'b0, done_p = 1'b0;
  int bitpos = 0, wpos = 0, low_cnt = 0, fif = 0;
  bit in_xfer = 1'b0, x_frame = 1'b0;
  int frames = 0, bad_frames = 0, total_falls = 0, dones = 0;
  int wide_err = 0, lock_err = 0, low_err = 0, lock_hits = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int n_words(input logic [1:0] m);
    return (m == 2'd1 || m == 2'd2) ? NUM_CH : NUM_CH / 2;
  endfunction

  function automatic logic [WORD_W-1:0] line_word(input bit b_line, input int w);
    if (w >= NUM_CH) return '0;
    case (x_mode)
      2'd1: return b_line ? junk[w] : exp_ch[w];
      2'd2: return b_line ? exp_ch[(w + NUM_CH/2) % NUM_CH] : junk[w];
      default: begin
        if (w >= NUM_CH/2) return '0;
        return b_line ? exp_ch[w + NUM_CH/2] : exp_ch[w];
      end
    endcase
  endfunction

  always @(negedge clk) begin
    logic [WORD_W-1:0] wa, wb;
    bit fell, rose;
    fell = sclk_p && !sclk_o;
    rose = !sclk_p && sclk_o;
    // R7 lockout observed at the pins
    if (fell && busy_p && !busy_i) lock_err++;
    if (!cs_n_o && busy_p && !busy_i) lock_hits++;
    busy_p = busy_i;
    if (busy_rand) begin
      if ($urandom % 3 == 0) busy_i = ~busy_i;
    end else begin
      busy_i = 1'b0;
    end
    // R8 low phase length
    if (rose) begin
      if (low_cnt != HALF_DIV) low_err++;
      low_cnt = 0;
    end
    if (!sclk_o) low_cnt++;
    if (fell && !cs_n_o) begin
      total_falls++;
      fif++;
    end
    // R10 strobe width
    if (done_p && done_o) wide_err++;
    if (done_o) dones++;
    done_p = done_o;
    // converter model
    if (cs_p && !cs_n_o) begin
      bitpos = 0;
      fif = 0;
      if (!in_xfer) begin
        wpos = 0;
        in_xfer = 1'b1;
      end
    end else if (rose && !cs_p) begin
      bitpos++;
      if (bitpos == WORD_W) begin
        bitpos = 0;
        wpos++;
      end
    end
    if (!cs_p && cs_n_o) begin
      frames++;
      if (fif != (x_frame ? WORD_W : WORD_W * n_words(x_mode))) bad_frames++;
    end
    if (done_o) in_xfer = 1'b0;
    wa = line_word(1'b0, wpos);
    wb = line_word(1'b1, wpos);
    sdo_a_i = wa[WORD_W-1-bitpos];
    sdo_b_i = wb[WORD_W-1-bitpos];
    sclk_p = sclk_o;
    cs_p = cs_n_o;
  end

  task automatic run_xfer(input logic [1:0] md, input bit fw, input bit brand,
                          input bit mid_start, input bit swap_in);
    string tag;
    int words;
    tag = (md == 2'd1) ? "R4" : (md == 2'd2) ? "R5" : "R3";
    words = n_words(md);
    @(posedge clk);
    for (int k = 0; k < NUM_CH; k++) begin
      exp_ch[k] = WORD_W'($urandom);
      junk[k] = WORD_W'($urandom);
    end
    x_mode = md;
    x_frame = fw;
    frames = 0; bad_frames = 0; total_falls = 0; dones = 0;
    wide_err = 0; lock_err = 0; low_err = 0;
    busy_rand = brand;
    @(negedge clk);
    mode_i = md;
    word_frame_i = fw;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (swap_in) begin
      mode_i = ~md;
      word_frame_i = ~fw;
    end
    if (mid_start) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      mode_i = md + 2'd1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    busy_rand = 1'b0;
    repeat (12) @(negedge clk);
    for (int k = 0; k < NUM_CH; k++) begin
      chk(ch_data_o[k*WORD_W +: WORD_W] == exp_ch[k],
          swap_in ? "R11" : $sformatf("R2/%s ch%0d", tag, k + 1),
          int'(ch_data_o[k*WORD_W +: WORD_W]), int'(exp_ch[k]));
    end
    chk(total_falls == words * WORD_W, tag, total_falls, words * WORD_W);
    chk(frames == (fw ? words : 1), "R6 frames", frames, fw ? words : 1);
    chk(bad_frames == 0, "R6 frame length", bad_frames, 0);
    chk(lock_err == 0, "R7", lock_err, 0);
    chk(low_err == 0, "R8", low_err, 0);
    chk(dones == 1, mid_start ? "R9" : "R10", dones, 1);
    chk(wide_err == 0, "R10 width", wide_err, 0);
    chk(cs_n_o == 1'b1, "R9 idle after", int'(cs_n_o), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cs_n_o && sclk_o && !done_o && ch_data_o == '0, "R1 in reset",
        int'({cs_n_o, sclk_o, done_o}), 6);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n_o && sclk_o && !done_o && ch_data_o == '0, "R1 after reset",
        int'({cs_n_o, sclk_o, done_o}), 6);
    // directed
    run_xfer(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_xfer(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_xfer(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    run_xfer(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_xfer(2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    run_xfer(2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    run_xfer(2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_xfer(2'd2, 1'b0, 1'b0, 1'b0, 1'b1);
    run_xfer(2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    // random mix
    for (int i = 0; i < 16; i++) begin
      run_xfer(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    // R7 coverage: BUSY fell inside frames at least once
    chk(lock_hits > 0, "R7 coverage", lock_hits, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule